// File: doc/BRIEF.md
# Eight-to-One Serializer with Rate Select

This block turns a stream of 8-bit parallel words into one serial bit stream driven from a single bit clock. A rate input picks one of two speeds. In single rate the block sends one bit per clock period. In double rate it sends two bits per period, one during the high phase and one during the low phase. Bit 0 of each word goes out first, and each word follows the one before it with no gap.

The block latches a new word every word time: 8 clock periods in single rate, 4 in double rate. It also produces a word clock with a 50% duty cycle, which tells the upstream logic when the latch happens. The word clock rises on the falling edge just after each latch. The upstream source should change the parallel bus after that rising edge and have it settled before the next latch edge. The interface has no back-pressure: the serializer sets the pace, and the source must keep up with the word clock. The delay from latch to output is fixed, so the serial position of every bit is known from the latch edge alone.

Top module: `ser8_top`

## Requirements
- R1: Within each word, bit 0 is sent first, then bits 1 to 7 in ascending order.
- R2: In single rate (rate_dbl = 0 at the latch edge), bit i of a word latched at rising edge E appears on ser_out at the falling edge after rising edge E+6+i. It stays there for one full clock period.
- R3: In double rate (rate_dbl = 1 at the latch edge), bit 2j of a word latched at rising edge E is on ser_out while clk is high after rising edge E+6+j. Bit 2j+1 follows while clk is low in the same period.
- R4: Words are latched back to back. The next word is latched at rising edge E+8 in single rate and at E+4 in double rate, so the output stream has no gap between words.
- R5: word_clk has a period of one word time in the current word's mode. It is high for the first half of that time: 4 periods in single rate, 2 in double rate.
- R6: word_clk changes only on falling edges of clk. It rises on the falling edge right after each latch edge.
- R7: While rst_n is low, ser_out and word_clk are 0. The first rising edge after release latches the first word. ser_out stays 0 until that word's first bit is due.
- R8: rate_dbl is sampled only at latch edges. A change between latch edges has no effect, so no word is ever split across two modes.
- R9: par_data is sampled only at latch edges. Its value at any other rising edge has no effect on ser_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_data | input | 8 | Parallel word, bit 0 sent first |
| rate_dbl | input | 1 | 0: one bit per period, 1: two bits per period |
| ser_out | output | 1 | Serial data |
| word_clk | output | 1 | Word-rate clock, 50% duty, changes on falling edges |

## Verification
The properties assume that par_data and rate_dbl are settled at every latch edge. They also assume that reset is applied away from a rising clock edge. To meet this, the stimulus changes its inputs only in the low phase of the clock. It drives the correct word and mode just before each latch edge and drives different values at every other rising edge, so anything sampled at the wrong edge shows up at the output. The period and duty checks assume that the mode seen on rate_dbl at the latch edge is the one that word uses. That is why the stimulus also inverts rate_dbl between latch edges.

// File: rtl/ser8_pkg.sv
package ser8_pkg;
  // One slot of the output pipeline: the two bits for one clock period
  // and the mode they belong to. In single rate both bits are equal.
  typedef struct packed {
    logic dbl;
    logic a;   // high-phase bit
    logic b;   // low-phase bit
  } slot_t;
endpackage

// File: rtl/ser8_seq.sv
// Rising-edge sequencer: latches the word and the mode at word boundaries
// and emits one bit slot per clock period.
module ser8_seq
  import ser8_pkg::*;
#(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  par_data,
  input  logic          rate_dbl,
  output logic          take,
  output slot_t         slot0,
  output logic [IW-1:0] emit_idx,
  output logic          emit_dbl,
  output logic          started
);
  logic [IW-1:0] ph;
  logic [W-1:0]  word_q;
  logic          mode_q;
  logic [W-1:0]  src_word;
  logic          src_dbl;
  logic [IW-1:0] last_ph;
  logic [IW-1:0] even_i;
  logic [IW-1:0] odd_i;
  slot_t         nxt;

  assign take     = (ph == '0);
  assign src_word = take ? par_data : word_q;
  assign src_dbl  = take ? rate_dbl : mode_q;
  assign last_ph  = src_dbl ? IW'(W/2 - 1) : IW'(W - 1);
  assign even_i   = {ph[IW-2:0], 1'b0};
  assign odd_i    = {ph[IW-2:0], 1'b1};

  always_comb begin
    nxt.dbl = src_dbl;
    if (src_dbl) begin
      nxt.a = src_word[even_i];
      nxt.b = src_word[odd_i];
    end else begin
      nxt.a = src_word[ph];
      nxt.b = src_word[ph];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= '0;
      word_q   <= '0;
      mode_q   <= 1'b0;
      slot0    <= '0;
      emit_idx <= '0;
      emit_dbl <= 1'b0;
      started  <= 1'b0;
    end else begin
      if (take) begin
        word_q <= par_data;
        mode_q <= rate_dbl;
      end
      ph       <= (ph == last_ph) ? '0 : ph + 1'b1;
      slot0    <= nxt;
      emit_idx <= ph;
      emit_dbl <= src_dbl;
      started  <= 1'b1;
    end
  end
endmodule

// File: rtl/ser8_delay.sv
// Fixed-length rising-edge delay line for bit slots.
module ser8_delay
  import ser8_pkg::*;
#(
  parameter int LAT = 6
) (
  input  logic  clk,
  input  logic  rst_n,
  input  slot_t din,
  output slot_t dout
);
  generate
    if (LAT == 0) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      slot_t stg [LAT];
      for (genvar i = 0; i < LAT; i++) begin : g_stg
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= (i == 0) ? din : stg[(i == 0) ? 0 : i-1];
        end
      end
      assign dout = stg[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/ser8_out.sv
// Falling-edge output stage: low-phase bit register, phase multiplexer
// and word clock generation.
module ser8_out
  import ser8_pkg::*;
#(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  slot_t         tail,
  input  logic [IW-1:0] emit_idx,
  input  logic          emit_dbl,
  input  logic          started,
  output logic          ser_out,
  output logic          word_clk
);
  logic          fall_q;
  logic [IW-1:0] half;

  assign half = emit_dbl ? IW'(W/4) : IW'(W/2);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q   <= 1'b0;
      word_clk <= 1'b0;
    end else begin
      fall_q   <= tail.b;
      word_clk <= started && (emit_idx < half);
    end
  end

  assign ser_out = (tail.dbl && clk) ? tail.a : fall_q;
endmodule

// File: rtl/ser8_top.sv
// Eight-to-one serializer, single or double data rate.
module ser8_top
  import ser8_pkg::*;
#(
  parameter int W   = 8,   // word width, power of two, at least 4
  parameter int LAT = 6    // rising-edge delay stages after the slot register
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] par_data,
  input  logic         rate_dbl,
  output logic         ser_out,
  output logic         word_clk
);
  localparam int IW = $clog2(W);

  logic          take;
  slot_t         slot0;
  slot_t         tail;
  logic [IW-1:0] emit_idx;
  logic          emit_dbl;
  logic          started;

  ser8_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .par_data(par_data), .rate_dbl(rate_dbl),
    .take(take), .slot0(slot0), .emit_idx(emit_idx), .emit_dbl(emit_dbl),
    .started(started)
  );

  ser8_delay #(.LAT(LAT)) u_dly (
    .clk(clk), .rst_n(rst_n), .din(slot0), .dout(tail)
  );

  ser8_out #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .tail(tail), .emit_idx(emit_idx),
    .emit_dbl(emit_dbl), .started(started), .ser_out(ser_out),
    .word_clk(word_clk)
  );
endmodule

// File: rtl/ser8_chk.sv
module ser8_chk #(
  parameter int W   = 8,
  parameter int LAT = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] par_data,
  input logic         rate_dbl,
  input logic         ser_out,
  input logic         word_clk,
  input logic         take
);
  logic [7:0] gap;
  logic [7:0] wlen;
  logic       have;
  logic       wclk_d;
  logic       rate_prev;
  logic       rose_w;
  logic       fell_w;

  assign rose_w = word_clk && !wclk_d;
  assign fell_w = !word_clk && wclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0; wlen <= 8'(W); have <= 1'b0; wclk_d <= 1'b0; rate_prev <= 1'b0;
    end else begin
      wclk_d    <= word_clk;
      rate_prev <= rate_dbl;
      if (rose_w) begin
        gap  <= 8'd1;
        have <= 1'b1;
        wlen <= rate_prev ? 8'(W/2) : 8'(W);
      end else begin
        gap <= gap + 8'd1;
      end
    end
  end

  // R7: outputs idle while reset is held
  p_reset_idle_r7: assert property (@(posedge clk)
    !rst_n |-> (ser_out == 1'b0 && word_clk == 1'b0));

  // R5: word clock period equals one word time of the word it framed
  p_wclk_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rose_w && have) |-> (gap == wlen));

  // R5: word clock high for half a word time
  p_wclk_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fell_w && have) |-> (gap == (wlen >> 1)));

  // R6: word clock only moves while clk is low
  always @(word_clk) begin
    if (rst_n) begin
      p_wclk_fall_r6: assert (!clk);
    end
  end

  generate
    if (LAT == 6) begin : g_lat
      // R2: first single-rate bit seen at the rising edge 7 after the latch
      p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(take && rst_n, 7) && !$past(rate_dbl, 7)) |-> (ser_out == $past(par_data[0], 7)));
      // R3: second double-rate bit in the low phase before that edge
      p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(take && rst_n, 7) && $past(rate_dbl, 7)) |-> (ser_out == $past(par_data[1], 7)));
    end
  endgenerate
endmodule

bind ser8_top ser8_chk #(.W(W), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .par_data(par_data), .rate_dbl(rate_dbl),
  .ser_out(ser_out), .word_clk(word_clk), .take(take)
);

// File: tb/ser8_top_test.sv
module ser8_top_test;
  localparam int NW   = 256;
  localparam int MAXE = 4096;

  logic       clk;
  logic       rst_n;
  logic [7:0] par_data;
  logic       rate_dbl;
  logic       ser_out;
  logic       word_clk;

  int n_chk;
  int n_fail;
  bit done;

  int start_e [0:NW+4];
  int exp_lo  [0:MAXE-1];
  int a_val   [0:MAXE-1];
  int dblm    [0:MAXE-1];
  int wlo     [0:MAXE-1];

  ser8_top uut (
    .clk(clk), .rst_n(rst_n), .par_data(par_data), .rate_dbl(rate_dbl),
    .ser_out(ser_out), .word_clk(word_clk)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  function automatic logic [7:0] word_of(int w);
    return (w < NW) ? 8'((w * 37 + 5) & 255) : 8'h00;
  endfunction

  function automatic logic mode_of(int w);
    return (w < NW) ? ((w % 7) < 3) : 1'b0;
  endfunction

  task automatic chk(string req, logic act, logic exp, int k, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s edge %0d: actual %b expected %b", req, what, k, act, exp);
    end
  endtask

  initial begin
    int last_k;
    int wn;
    n_chk = 0; n_fail = 0; done = 0;
    for (int i = 0; i < MAXE; i++) begin
      exp_lo[i] = 0; a_val[i] = 0; dblm[i] = 0; wlo[i] = 0;
    end
    // R4: latch edges spaced by word length of the previous word
    start_e[0] = 0;
    for (int w = 1; w <= NW + 4; w++)
      start_e[w] = start_e[w-1] + (mode_of(w-1) ? 4 : 8);
    for (int w = 0; w <= NW; w++) begin
      int e;
      logic [7:0] d;
      e = start_e[w];
      d = word_of(w);
      if (mode_of(w)) begin
        for (int j = 0; j < 4; j++) begin
          a_val[e+6+j]  = d[2*j];
          exp_lo[e+6+j] = d[2*j+1];
          dblm[e+6+j]   = 1;
          wlo[e+j]      = (j < 2);
        end
      end else begin
        for (int i = 0; i < 8; i++) begin
          exp_lo[e+6+i] = d[i];
          dblm[e+6+i]   = 0;
          wlo[e+i]      = (i < 4);
        end
      end
    end
    last_k = start_e[NW] + 5;

    // R7: reset state
    rst_n = 1'b1; par_data = word_of(0); rate_dbl = mode_of(0);
    #1 rst_n = 1'b0;
    #4;
    chk("R7", ser_out, 1'b0, -1, "ser_out in reset");
    chk("R7", word_clk, 1'b0, -1, "word_clk in reset");
    #4 rst_n = 1'b1;   // t=9, first rising edge at t=10 is edge 0

    wn = 1;
    for (int k = 0; k <= last_k; k++) begin
      logic eh;
      logic whi;
      @(posedge clk);
      #1;
      // R1 R2 R3: high-phase bit; single-rate holds the previous low-phase bit
      eh  = (dblm[k] != 0) ? a_val[k][0] : ((k > 0) ? exp_lo[k-1][0] : 1'b0);
      chk((dblm[k] != 0) ? "R3" : "R2", ser_out, eh, k, "ser_out high phase");
      // R5 R6: word clock only changed at the previous falling edge
      whi = (k > 0) ? wlo[k-1][0] : 1'b0;
      chk("R6", word_clk, whi, k, "word_clk high phase");
      #2;
      // R1 R4 R8 R9: low-phase bit from the correct word and mode
      chk("R1", ser_out, exp_lo[k][0], k, "ser_out low phase");
      chk("R5", word_clk, wlo[k][0], k, "word_clk low phase");
      if (k + 1 == start_e[wn]) begin
        par_data = word_of(wn);
        rate_dbl = mode_of(wn);
        wn++;
      end else begin
        // R8 R9: non-latch edges see unrelated data and the opposite mode
        par_data = 8'((k * 91 + 3) & 255);
        rate_dbl = ~mode_of(wn - 1);
      end
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #80000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule